// File: doc/BRIEF.md
# CAN Controller Interrupt Combiner

This block gathers the interrupt causes of a small CAN controller onto one shared request line, so the whole group is served by a single common service routine. It watches three kinds of event:

- a change in the controller's error-status or bus-status bits;
- a message arriving while both receive buffers are still occupied;
- bus activity while the controller is asleep.

Each event latches a sticky flag. Software reads the flags, sets the mask bits and acknowledges the flags through a small register port. The request output is registered.

The error and overrun causes each have an enable bit. The wake-up cause has no mask. When it is pending it always raises the request.

Top module: `can_irq_combiner`

## Requirements
- R1: After reset, the flag register, the enable register, `sw_rdata_o` and `irq_o` are all zero.
- R2: A change in any bit of `err_status_i` or `bus_status_i` sets the error flag (flag bit 0) at the next clock edge. A status that holds steady at any value, zero or not, does not set it again after it is cleared.
- R3: Status values held during reset are taken as the reference. Releasing reset with nonzero status produces no error flag.
- R4: `rx_arrive_i` sets the overrun flag (flag bit 1) when both `rx_buf0_full_i` and `rx_buf1_full_i` are high. An arrival while at most one buffer is full leaves the flag clear.
- R5: `bus_active_i` sets the wake-up flag (flag bit 2) only while `sleep_mode_i` is high. Activity outside sleep mode leaves it clear.
- R6: Flags are sticky. Writing to the flag register (`sw_sel_i`=0) clears exactly those flags whose `sw_wdata_i` bit is one. Zero bits leave their flags unchanged.
- R7: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is a register. One cycle after the flags and enables settle, it equals (error flag AND enable bit 0) OR (overrun flag AND enable bit 1) OR the wake-up flag. The enable register is written at `sw_sel_i`=1 from `sw_wdata_i[1:0]`.
- R9: `sw_rdata_o` is registered. It shows the register chosen by `sw_sel_i` (0 = flags, 1 = enables) as it stood before the same clock edge, zero-extended. Enable bit 2 and above always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_status_i | input | ERR_W | Error-status bits from the protocol engine |
| bus_status_i | input | BUS_W | Bus-status bits from the protocol engine |
| rx_arrive_i | input | 1 | One-cycle strobe: a new message has arrived |
| rx_buf0_full_i | input | 1 | Receive buffer 0 is occupied |
| rx_buf1_full_i | input | 1 | Receive buffer 1 is occupied |
| sleep_mode_i | input | 1 | Controller is in sleep mode |
| bus_active_i | input | 1 | Activity seen on the bus |
| sw_sel_i | input | 1 | Register select: 0 flags, 1 enables |
| sw_wr_i | input | 1 | Write strobe for the selected register |
| sw_wdata_i | input | DW | Write data (one-to-clear for flags) |
| sw_rdata_o | output | DW | Registered read data of the selected register |
| irq_o | output | 1 | Registered shared interrupt request |

## Verification
An event or write that is sampled at clock edge k updates the flag and enable registers at edge k. The read data and the request follow one edge later, at k+1.

The bench drives every input on a falling edge. It then waits two falling edges before it compares the read data or the request, which places each sample half a cycle after the edge that produced it.

Read-back alone needs only one falling edge after the select changes. The ignore cases check the flag register at that same two-edge point, after the stimulus and before anything else is applied.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int SRC_ERR  = 0;
  localparam int SRC_OVR  = 1;
  localparam int SRC_WAKE = 2;
  localparam int NUM_SRC  = 3;
  localparam int NUM_MASK = 2;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/status_change_det.sv
module status_change_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur_i,
  output logic         changed_o
);
  logic [W-1:0] prev_q;

  // The copy tracks the input during reset too, so that leaving reset is not an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= cur_i;
    else     prev_q <= cur_i;
  end

  assign changed_o = !rst && (cur_i != prev_q);

  assert_change_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_i != $past(cur_i)) |-> changed_o);
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/can_irq_combiner.sv
module can_irq_combiner
  import can_irq_pkg::*;
#(
  parameter int ERR_W = 2,
  parameter int BUS_W = 2,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err_status_i,
  input  logic [BUS_W-1:0] bus_status_i,
  input  logic             rx_arrive_i,
  input  logic             rx_buf0_full_i,
  input  logic             rx_buf1_full_i,
  input  logic             sleep_mode_i,
  input  logic             bus_active_i,
  input  logic             sw_sel_i,
  input  logic             sw_wr_i,
  input  logic [DW-1:0]    sw_wdata_i,
  output logic [DW-1:0]    sw_rdata_o,
  output logic             irq_o
);
  localparam int STAT_W = ERR_W + BUS_W;

  logic                status_chg;
  logic [NUM_SRC-1:0]  src_set;
  logic [NUM_SRC-1:0]  src_clr;
  logic [NUM_SRC-1:0]  flag_q;
  logic [NUM_MASK-1:0] en_q;
  logic [NUM_SRC-1:0]  eff_mask;
  logic                flag_wr;
  logic                en_wr;

  status_change_det #(.W(STAT_W)) u_chg (
    .clk      (clk),
    .rst      (rst),
    .cur_i    ({err_status_i, bus_status_i}),
    .changed_o(status_chg)
  );

  always_comb begin
    src_set           = '0;
    src_set[SRC_ERR]  = status_chg;
    src_set[SRC_OVR]  = rx_arrive_i && rx_buf0_full_i && rx_buf1_full_i;
    src_set[SRC_WAKE] = sleep_mode_i && bus_active_i;
  end

  assign flag_wr = sw_wr_i && (reg_sel_e'(sw_sel_i) == SEL_FLAGS);
  assign en_wr   = sw_wr_i && (reg_sel_e'(sw_sel_i) == SEL_ENABLE);
  assign src_clr = flag_wr ? sw_wdata_i[NUM_SRC-1:0] : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    irq_flag_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (src_set[i]),
      .clr_i (src_clr[i]),
      .flag_o(flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= sw_wdata_i[NUM_MASK-1:0];
  end

  // The wake-up source is outside the mask register and is always enabled.
  assign eff_mask = {1'b1, en_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      sw_rdata_o <= '0;
    end else begin
      irq_o <= |(flag_q & eff_mask);
      if (reg_sel_e'(sw_sel_i) == SEL_ENABLE)
        sw_rdata_o <= {{(DW-NUM_MASK){1'b0}}, en_q};
      else
        sw_rdata_o <= {{(DW-NUM_SRC){1'b0}}, flag_q};
    end
  end

  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_arrive_i && rx_buf0_full_i && rx_buf1_full_i) |=> flag_q[SRC_OVR]);
  assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    (!flag_q[SRC_OVR] && !(rx_buf0_full_i && rx_buf1_full_i)) |=> !flag_q[SRC_OVR]);
  assert_wake_set_R5: assert property (@(posedge clk) disable iff (rst)
    (sleep_mode_i && bus_active_i) |=> flag_q[SRC_WAKE]);
  assert_awake_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!flag_q[SRC_WAKE] && !sleep_mode_i) |=> !flag_q[SRC_WAKE]);
  assert_wake_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
    flag_q[SRC_WAKE] |=> irq_o);
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!flag_q[SRC_WAKE] && !(flag_q[SRC_ERR] && en_q[0]) && !(flag_q[SRC_OVR] && en_q[1]))
      |=> !irq_o);
endmodule

// File: tb/can_irq_combiner_tb.sv
module can_irq_combiner_tb;
  localparam int ERR_W = 2;
  localparam int BUS_W = 2;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ERR_W-1:0] err_status = '0;
  logic [BUS_W-1:0] bus_status = '0;
  logic rx_arrive = 0, buf0 = 0, buf1 = 0, sleep = 0, active = 0;
  logic sel = 0, wr = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_irq_combiner #(.ERR_W(ERR_W), .BUS_W(BUS_W), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .err_status_i(err_status), .bus_status_i(bus_status),
    .rx_arrive_i(rx_arrive), .rx_buf0_full_i(buf0), .rx_buf1_full_i(buf1),
    .sleep_mode_i(sleep), .bus_active_i(active), .sw_sel_i(sel), .sw_wr_i(wr),
    .sw_wdata_i(wdata), .sw_rdata_o(rdata), .irq_o(irq)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic w1c(logic [DW-1:0] m);
    sel = 1'b0; wr = 1'b1; wdata = m;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic wr_en(logic [DW-1:0] v);
    sel = 1'b1; wr = 1'b1; wdata = v;
    step();
    wr = 1'b0; wdata = '0; sel = 1'b0;
  endtask

  task automatic t_reset;
    err_status = 2'b11; bus_status = 2'b01; rst = 1'b1;
    step(3);
    rst = 1'b0;
    step();
    chk("R1", "rdata after reset", rdata, 0);
    chk("R1", "irq after reset", irq, 0);
    step(2);
    chk("R3", "no error flag leaving reset", rdata, 0);
    sel = 1'b1; step();
    chk("R1", "enables after reset", rdata, 0);
    sel = 1'b0; step();
  endtask

  task automatic t_error;
    bus_status = 2'b00;
    step(2);
    chk("R2", "bus status change", rdata, 8'h01);
    chk("R8", "masked error no irq", irq, 0);
    w1c(8'h01); step();
    chk("R6", "error cleared", rdata, 0);
    step(3);
    chk("R2", "steady level no re-set", rdata, 0);
    err_status = 2'b01;
    step(2);
    chk("R2", "error status change", rdata, 8'h01);
    w1c(8'h01); step();
  endtask

  task automatic t_overrun;
    buf0 = 1; buf1 = 0; rx_arrive = 1;
    step(); rx_arrive = 0; step();
    chk("R4", "one buffer full ignored", rdata, 0);
    buf1 = 1; rx_arrive = 1;
    step(); rx_arrive = 0; step();
    chk("R4", "both full overrun", rdata, 8'h02);
    w1c(8'h00); step();
    chk("R6", "zero write keeps flag", rdata, 8'h02);
    w1c(8'h02); step();
    chk("R6", "overrun cleared", rdata, 0);
  endtask

  task automatic t_set_wins;
    rx_arrive = 1; sel = 0; wr = 1; wdata = 8'h02;
    step();
    rx_arrive = 0; wr = 0; wdata = '0;
    step();
    chk("R7", "set beats clear", rdata, 8'h02);
  endtask

  task automatic t_mask;
    chk("R8", "overrun masked", irq, 0);
    wr_en(8'h02); step();
    chk("R8", "overrun enabled irq", irq, 1);
    sel = 1'b1; step();
    chk("R9", "enable readback", rdata, 8'h02);
    wr_en(8'hFF); sel = 1'b1; step();
    chk("R9", "enable upper bits read zero", rdata, 8'h03);
    sel = 1'b0;
    w1c(8'h02); step();
    chk("R8", "irq drops after clear", irq, 0);
    bus_status = 2'b10;
    step(2);
    chk("R8", "error enabled irq", irq, 1);
    w1c(8'h01); wr_en(8'h00); step();
    chk("R8", "irq off", irq, 0);
  endtask

  task automatic t_wake;
    buf0 = 0; buf1 = 0;
    active = 1; step(); active = 0; step();
    chk("R5", "activity while awake ignored", rdata, 0);
    sleep = 1; active = 1; step(); active = 0; sleep = 0; step();
    chk("R5", "wake flag", rdata, 8'h04);
    chk("R8", "wake unmasked irq", irq, 1);
    w1c(8'h04); step();
    chk("R6", "wake cleared", rdata, 0);
    chk("R8", "irq after wake clear", irq, 0);
  endtask

  initial begin
    t_reset();
    t_error();
    t_overrun();
    t_set_wins();
    t_mask();
    t_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule